// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Loader

This block holds the digital register state of a two-channel converter that is written over a parallel bus. Each channel has two register levels. A word presented on the data bus enters the first-level (staging) register of the channel named by the address bit. The second-level (output) registers drive the converter codes. A shared active-low load strobe moves both staging words into the output registers on the same clock edge, so both outputs change together. Holding load low during a write makes the addressed output register take the new word on the same edge it is staged.

The bus strobes are active low. A staging register is written on the rising edge of the write strobe while chip-select is low, and the edge is found by sampling the strobe with the block clock. An asynchronous active-low clear forces all staging and output registers to zero and holds them there for as long as it stays low. The clear overrides any write or load. An active-low power-down input sets a power-down flag for each channel. The gain range select is registered and presented as a status bit. The reference buffer select is passed straight through.

Top module: `dac_pair_loader`

## Requirements
- R1: After power-on reset, both output codes are zero, both power-down flags are 0 and the gain status is 0.
- R2: When the write strobe rises while chip-select is low, the addressed staging register takes the data bus value, with bit 11 as the MSB. While load is high, the output codes do not change.
- R3: A rising edge of the write strobe while chip-select is high writes no staging register. A later load shows the earlier contents.
- R4: Address 0 selects channel A and address 1 selects channel B. A write never changes the other channel.
- R5: While load is low, every output register takes its staging value on each clock edge, so both channels update on the same edge.
- R6: If load is low on the edge that completes a write, the addressed output register takes the new word on that same edge.
- R7: Clear low zeroes every staging and output register at once, without waiting for a clock edge. The registers stay zero while clear is low, whatever the write and load strobes do.
- R8: One clock edge after the power-down input is sampled low, both power-down flags read 1. One edge after it is sampled high, both read 0.
- R9: The gain status shows the gain select value sampled on the previous clock edge. The buffer control output equals the buffer select input with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the strobes |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| csN | input | 1 | Active-low chip-select |
| wrN | input | 1 | Active-low write strobe; the rising edge completes a write |
| addrSel | input | 1 | Channel address: 0 = A, 1 = B |
| dataIn | input | 12 | Parallel data word, bit 11 MSB |
| loadN | input | 1 | Active-low simultaneous update strobe |
| clrN | input | 1 | Asynchronous active-low clear of all code registers |
| pwrDnN | input | 1 | Active-low power-down request |
| gainSel | input | 1 | Output span select (0 = 1x, 1 = 2x reference) |
| bufSel | input | 1 | Reference buffer select |
| dacValA | output | 12 | Channel A output register |
| dacValB | output | 12 | Channel B output register |
| pwrDnFlag | output | 2 | Per-channel power-down flags (bit 0 = A) |
| gainStat | output | 1 | Registered gain select |
| bufCtl | output | 1 | Buffer select pass-through |

## Verification
The bench walks a single one and its complement through all twelve bit positions and writes the two patterns to channels A and B at the same time. A swapped address, a channel that writes the wrong register, or a bit-order fault therefore shows up as a mismatch in a particular position. Write cycles with chip-select high are placed between real writes, so a chip-select that is ignored gets caught. Holding load low during a write separates the transparent path from the plain two-step update. A clear is issued while writes and loads are attempted, which shows whether clear overrides the other strobes and whether it acts without a clock edge.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;
  localparam int CH_COUNT = 2;

  typedef struct packed {
    logic [CH_COUNT-1:0] wrHit;
    logic                loadAll;
  } ctrlStrobes_t;
endpackage

// File: rtl/dac_pair_ctrl.sv
module dac_pair_ctrl
  import dac_pair_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         wrN,
  input  logic         addrSel,
  input  logic         loadN,
  output ctrlStrobes_t strobes
);
  logic wrPrev;
  logic wrEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b1;
    else       wrPrev <= wrN;
  end

  assign wrEdge = wrN && !wrPrev && !csN;

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_hit
    assign strobes.wrHit[g] = wrEdge && (int'(addrSel) == g);
  end

  assign strobes.loadAll = !loadN;
endmodule

// File: rtl/dac_pair_datapath.sv
module dac_pair_datapath
  import dac_pair_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            clrAllN,
  input  ctrlStrobes_t                    strobes,
  input  logic [DATA_W-1:0]               dataIn,
  input  logic                            pwrDnN,
  input  logic                            gainSel,
  output logic [CH_COUNT-1:0][DATA_W-1:0] dacVal,
  output logic [CH_COUNT-1:0]             pwrDnFlag,
  output logic                            gainStat
);
  logic [CH_COUNT-1:0][DATA_W-1:0] stageReg;

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
    always_ff @(posedge clk or negedge clrAllN) begin
      if (!clrAllN)               stageReg[g] <= '0;
      else if (strobes.wrHit[g])  stageReg[g] <= dataIn;
    end

    always_ff @(posedge clk or negedge clrAllN) begin
      if (!clrAllN)               dacVal[g] <= '0;
      else if (strobes.loadAll)   dacVal[g] <= strobes.wrHit[g] ? dataIn : stageReg[g];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pwrDnFlag[g] <= 1'b0;
      else       pwrDnFlag[g] <= !pwrDnN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gainStat <= 1'b0;
    else       gainStat <= gainSel;
  end
endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader
  import dac_pair_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              loadN,
  input  logic              clrN,
  input  logic              pwrDnN,
  input  logic              gainSel,
  input  logic              bufSel,
  output logic [DATA_W-1:0] dacValA,
  output logic [DATA_W-1:0] dacValB,
  output logic [1:0]        pwrDnFlag,
  output logic              gainStat,
  output logic              bufCtl
);
  ctrlStrobes_t                    strobes;
  logic [CH_COUNT-1:0][DATA_W-1:0] dacVal;
  logic                            clrAllN;

  assign clrAllN = rstN && clrN;

  dac_pair_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .wrN     (wrN),
    .addrSel (addrSel),
    .loadN   (loadN),
    .strobes (strobes)
  );

  dac_pair_datapath #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .clrAllN   (clrAllN),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .pwrDnN    (pwrDnN),
    .gainSel   (gainSel),
    .dacVal    (dacVal),
    .pwrDnFlag (pwrDnFlag),
    .gainStat  (gainStat)
  );

  assign dacValA = dacVal[0];
  assign dacValB = dacVal[1];
  assign bufCtl  = bufSel;
endmodule

// File: rtl/dac_pair_loader_checker.sv
module dac_pair_loader_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrN,
  input logic              loadN,
  input logic              pwrDnN,
  input logic              gainSel,
  input logic              bufSel,
  input logic [DATA_W-1:0] dacValA,
  input logic [DATA_W-1:0] dacValB,
  input logic [1:0]        pwrDnFlag,
  input logic              gainStat,
  input logic              bufCtl
);
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (dacValA == '0 && dacValB == '0));

  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    loadN |=> ($stable(dacValA) && $stable(dacValB)));

  a_r8_power_down: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> pwrDnFlag == 2'b11);

  a_r8_power_up: assert property (@(posedge clk) disable iff (!rstN)
    pwrDnN |=> pwrDnFlag == 2'b00);

  a_r9_gain_registered: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> gainStat == $past(gainSel));

  always_comb begin
    a_r9_buf_pass: assert (bufCtl === bufSel);
  end
endmodule

bind dac_pair_loader dac_pair_loader_checker #(.DATA_W(DATA_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .clrN      (clrN),
  .loadN     (loadN),
  .pwrDnN    (pwrDnN),
  .gainSel   (gainSel),
  .bufSel    (bufSel),
  .dacValA   (dacValA),
  .dacValB   (dacValB),
  .pwrDnFlag (pwrDnFlag),
  .gainStat  (gainStat),
  .bufCtl    (bufCtl)
);

// File: tb/dac_pair_loader_bench.sv
`timescale 1ns/1ps
module dac_pair_loader_bench;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, addrSel = 1'b0, loadN = 1'b1, clrN = 1'b1;
  logic pwrDnN = 1'b1, gainSel = 1'b0, bufSel = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dacValA, dacValB;
  logic [1:0] pwrDnFlag;
  logic gainStat, bufCtl;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [W-1:0] modelIn [2];
  logic [W-1:0] modelDac [2];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  dac_pair_loader #(.DATA_W(W)) u_dac_pair_loader (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .addrSel(addrSel),
    .dataIn(dataIn), .loadN(loadN), .clrN(clrN), .pwrDnN(pwrDnN),
    .gainSel(gainSel), .bufSel(bufSel), .dacValA(dacValA), .dacValB(dacValB),
    .pwrDnFlag(pwrDnFlag), .gainStat(gainStat), .bufCtl(bufCtl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic ch, input logic [W-1:0] val, input logic selHigh);
    @(negedge clk); csN = selHigh; wrN = 1'b0; addrSel = ch; dataIn = val;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
    if (!selHigh) modelIn[ch] = val;
  endtask

  task automatic pulseLoad();
    @(negedge clk); loadN = 1'b0;
    @(negedge clk); loadN = 1'b1;
    modelDac[0] = modelIn[0];
    modelDac[1] = modelIn[1];
  endtask

  task automatic chkDacs(input string req);
    chk(req, 32'(dacValA), 32'(modelDac[0]));
    chk(req, 32'(dacValB), 32'(modelDac[1]));
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelIn[0] = '0; modelIn[1] = '0; modelDac[0] = '0; modelDac[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkDacs("R1");
    chk("R1", 32'(pwrDnFlag), 0);
    chk("R1", 32'(gainStat), 0);

    // R2 R4 R5: walking one and complement across both channels
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] pat;
      pat = W'(1) << i;
      busWrite(1'b0, pat, 1'b0);
      busWrite(1'b1, ~pat, 1'b0);
      chkDacs("R2 no change before load");
      pulseLoad();
      chkDacs("R4 R5 simultaneous load");
      // R3 writes with chip-select high are ignored
      busWrite(1'b0, 12'h5A5, 1'b1);
      busWrite(1'b1, 12'hA5A, 1'b1);
      pulseLoad();
      chkDacs("R3 cs high ignored");
    end

    // R4 single channel write leaves the other alone
    busWrite(1'b1, 12'h123, 1'b0);
    pulseLoad();
    chkDacs("R4 channel B only");

    // R6 transparent update with load held low
    @(negedge clk); loadN = 1'b0;
    busWrite(1'b0, 12'hABC, 1'b0);
    chk("R6 transparent A", 32'(dacValA), 32'h0ABC);
    busWrite(1'b1, 12'h0F1, 1'b0);
    chk("R6 transparent B", 32'(dacValB), 32'h00F1);
    @(negedge clk); loadN = 1'b1;
    modelDac[0] = 12'hABC; modelDac[1] = 12'h0F1;

    // R7 asynchronous clear, priority over strobes
    @(negedge clk); #1 clrN = 1'b0;
    #0.2;
    chk("R7 async clear A", 32'(dacValA), 0);
    chk("R7 async clear B", 32'(dacValB), 0);
    @(negedge clk); loadN = 1'b0;
    busWrite(1'b0, 12'hFFF, 1'b0);
    chk("R7 clear held A", 32'(dacValA), 0);
    chk("R7 clear held B", 32'(dacValB), 0);
    @(negedge clk); loadN = 1'b1; clrN = 1'b1;
    modelIn[0] = '0; modelIn[1] = '0; modelDac[0] = '0; modelDac[1] = '0;
    pulseLoad();
    chkDacs("R7 staging cleared");

    // R8 power-down
    @(negedge clk); pwrDnN = 1'b0;
    @(negedge clk);
    chk("R8 powered down", 32'(pwrDnFlag), 3);
    pwrDnN = 1'b1;
    @(negedge clk);
    chk("R8 powered up", 32'(pwrDnFlag), 0);

    // R9 gain registered, buffer pass-through
    gainSel = 1'b1; bufSel = 1'b1;
    #0.5;
    chk("R9 buf immediate", 32'(bufCtl), 1);
    chk("R9 gain not yet", 32'(gainStat), 0);
    @(negedge clk);
    chk("R9 gain registered", 32'(gainStat), 1);
    gainSel = 1'b0; bufSel = 1'b0;
    #0.5;
    chk("R9 buf low", 32'(bufCtl), 0);
    @(negedge clk);
    chk("R9 gain low", 32'(gainStat), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule